// File: doc/BRIEF.md
# Serial Flash Memory-Mapped Read Sequencer

This block lets a simple on-chip read bus fetch words straight out of a serial flash device. When memory-mapped mode is on, each bus read becomes one complete flash read: chip select falls, an optional command byte is shifted out, then up to four address bytes, then a run of dummy clocks, and then the data bytes are shifted in. Chip select then rises and the packed word goes back to the requester with a one-cycle acknowledge.

Each of the three outgoing stretches has its own lane width: one, two or four data lanes. This allows legacy single-lane reads and fast quad reads with the same hardware. When memory-mapped mode is off, the flash pins are handed to a set of direct pin inputs, which a register-driven transfer engine elsewhere uses. A bus read in that state is refused with an error response.

All format fields are static inputs that software sets up before reads are issued. They must stay stable while a read is in flight.

Top module: `sflash_map_reader`

## Requirements
- R1: While `mapEnable` is 0, `flashCsN`, `flashSck`, `flashDo` and `flashOe` equal `dirCsN`, `dirSck`, `dirDo` and `dirOe`. A bus read in that state is answered one cycle after acceptance with `busAck`=1, `busErr`=1 and `busRdata`=0.
- R2: With `mapEnable`=1, a bus read lowers `flashCsN` and then sends its parts in this fixed order: command, address, dummy, data. Parts of zero length are skipped. `flashCsN` stays low until the last data step ends.
- R3: The 8-bit value `cmdCode` is sent first only when `cmdEnable`=1. Otherwise the transaction starts with the next non-empty part.
- R4: `addrBytes` gives the number of address bytes, 0 to 4. Values 5 to 7 act as 4. The bytes are the low bytes of `busAddr`, most significant byte first.
- R5: `padCycles` (0 to 31) sets the number of dummy SCK cycles. In dummy cycle k, for k < 8, DQ0 is driven with bit 7-k of `padCode` and only lane 0 is enabled. From cycle 8 onward no lane is driven.
- R6: The fields `cmdLanes`, `addrLanes` and `dataLanes` select the width of their parts. 0 means single: output on DQ0, input on DQ1. 1 means dual: DQ1 carries the more significant bit. 2 or 3 means quad: DQ3 carries the most significant bit. Every byte is sent and received MSB first, and the output enables cover exactly the active lanes.
- R7: Each read fetches 4 data bytes with all output enables off. The first byte received lands in `busRdata[7:0]` and the last in `busRdata[31:24]`.
- R8: SCK works in mode 0. It is low while chip select is high. Output data changes only while SCK is low and input is sampled as SCK rises. Each SCK period is 2*SCK_HALF clocks, so a read takes 1 + 2*SCK_HALF*steps cycles from acceptance to the acknowledge.
- R9: `busAck` is a one-cycle pulse. On a successful read it comes with `flashCsN` high and `busErr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mapEnable | input | 1 | Memory-mapped mode on; 0 hands pins to direct inputs |
| cmdEnable | input | 1 | Send a command byte first |
| cmdCode | input | 8 | Command byte value |
| addrBytes | input | 3 | Address byte count (0..4, above 4 acts as 4) |
| padCycles | input | 5 | Dummy SCK cycle count |
| padCode | input | 8 | Pattern driven on DQ0 during the first 8 dummy cycles |
| cmdLanes | input | 2 | Command lane width code |
| addrLanes | input | 2 | Address lane width code |
| dataLanes | input | 2 | Data lane width code |
| dirCsN | input | 1 | Direct chip select |
| dirSck | input | 1 | Direct serial clock |
| dirDo | input | 4 | Direct lane outputs |
| dirOe | input | 4 | Direct lane output enables |
| busReq | input | 1 | Read request, held until acknowledge |
| busAddr | input | 32 | Read address |
| busAck | output | 1 | Read completion pulse |
| busErr | output | 1 | Read refused |
| busRdata | output | 32 | Read word |
| flashCsN | output | 1 | Flash chip select, active low |
| flashSck | output | 1 | Flash serial clock |
| flashDo | output | 4 | Lane output values |
| flashOe | output | 4 | Lane output enables |
| flashDi | input | 4 | Lane input values |

## Verification
The assertions check, on every cycle, the framing rules that hold whatever the format is. SCK stays low and never rises while chip select is high, the acknowledge is a single pulse, a successful acknowledge comes with chip select released, and an error response carries a zero word. Only the bench scenarios can show that the bits on the lanes follow the programmed format. They check command, address and pad bytes in the right order and at the right width, skipping of empty parts, clamping of the address length, little-endian packing of quad, dual and single data, and the exact cycle count of each read. The bench uses a flash model that records every rising SCK edge.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_CMD  = 3'd1,
    PH_ADDR = 3'd2,
    PH_PAD  = 3'd3,
    PH_DATA = 3'd4,
    PH_DONE = 3'd5,
    PH_FAIL = 3'd6
  } phase_t;

  // Strobes and position handed from the sequencer to the datapath.
  typedef struct packed {
    phase_t     phase;
    logic [1:0] lanes;      // normalised: 0 single, 1 dual, 2 quad
    logic [4:0] stepIdx;    // SCK step within the current byte or pad run
    logic [2:0] byteIdx;    // byte within the current part
    logic       sckHigh;
    logic       sampleEn;   // SCK about to rise in the data part
    logic       sampleLast; // that sample completes a byte
    logic       capture;    // accept a mapped read this cycle
  } seq_ctl_t;

  function automatic logic [1:0] normLanes(input logic [1:0] code);
    return (code == 2'd3) ? 2'd2 : code;
  endfunction

  function automatic logic [4:0] stepsPerByte(input logic [1:0] lanesN);
    return 5'd8 >> lanesN;
  endfunction

  function automatic logic isActive(input phase_t p);
    return (p == PH_CMD) || (p == PH_ADDR) || (p == PH_PAD) || (p == PH_DATA);
  endfunction

endpackage

// File: rtl/sfr_ctrl.sv
module sfr_ctrl
  import sfr_pkg::*;
#(
  parameter int SCK_HALF   = 1,
  parameter int DATA_BYTES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busReq,
  input  logic       mapEnable,
  input  logic       cmdEnable,
  input  logic [2:0] addrBytes,
  input  logic [4:0] padCycles,
  input  logic [1:0] cmdLanes,
  input  logic [1:0] addrLanes,
  input  logic [1:0] dataLanes,
  output seq_ctl_t   ctl
);

  localparam int HALF_W = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
  localparam logic [HALF_W-1:0] HALF_LAST = HALF_W'(SCK_HALF - 1);
  localparam logic [2:0] DATA_LAST = 3'(DATA_BYTES - 1);

  phase_t            phase;
  logic [HALF_W-1:0] halfCnt;
  logic              sckHigh;
  logic [4:0]        stepIdx;
  logic [2:0]        byteIdx;

  logic [1:0] lanesNow;
  logic [4:0] spb;
  logic [2:0] addrLen;
  logic       halfEnd, stepEnd, lastStep, lastByte;
  phase_t     afterCmd, afterAddr, firstPhase, nextPhase;

  always_comb begin
    unique case (phase)
      PH_CMD:  lanesNow = normLanes(cmdLanes);
      PH_ADDR: lanesNow = normLanes(addrLanes);
      PH_DATA: lanesNow = normLanes(dataLanes);
      default: lanesNow = 2'd0;
    endcase
  end

  assign spb     = stepsPerByte(lanesNow);
  assign addrLen = (addrBytes > 3'd4) ? 3'd4 : addrBytes;
  assign halfEnd = (halfCnt == HALF_LAST);
  assign stepEnd = sckHigh && halfEnd;

  always_comb begin
    if (phase == PH_PAD) lastStep = (stepIdx == padCycles - 5'd1);
    else                 lastStep = (stepIdx == spb - 5'd1);
  end

  always_comb begin
    unique case (phase)
      PH_ADDR: lastByte = (byteIdx == addrLen - 3'd1);
      PH_DATA: lastByte = (byteIdx == DATA_LAST);
      default: lastByte = 1'b1;
    endcase
  end

  // Part ordering with empty parts skipped.
  always_comb begin
    afterAddr  = (padCycles != 5'd0) ? PH_PAD : PH_DATA;
    afterCmd   = (addrLen != 3'd0) ? PH_ADDR : afterAddr;
    firstPhase = cmdEnable ? PH_CMD : afterCmd;
    unique case (phase)
      PH_CMD:  nextPhase = afterCmd;
      PH_ADDR: nextPhase = afterAddr;
      PH_PAD:  nextPhase = PH_DATA;
      PH_DATA: nextPhase = PH_DONE;
      default: nextPhase = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      halfCnt <= '0;
      sckHigh <= 1'b0;
      stepIdx <= '0;
      byteIdx <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          halfCnt <= '0;
          sckHigh <= 1'b0;
          stepIdx <= '0;
          byteIdx <= '0;
          if (busReq) phase <= mapEnable ? firstPhase : PH_FAIL;
        end
        PH_DONE, PH_FAIL: phase <= PH_IDLE;
        default: begin
          if (halfEnd) begin
            halfCnt <= '0;
            sckHigh <= !sckHigh;
          end else begin
            halfCnt <= halfCnt + HALF_W'(1);
          end
          if (stepEnd) begin
            if (lastStep) begin
              stepIdx <= '0;
              if (lastByte) begin
                byteIdx <= '0;
                phase   <= nextPhase;
              end else begin
                byteIdx <= byteIdx + 3'd1;
              end
            end else begin
              stepIdx <= stepIdx + 5'd1;
            end
          end
        end
      endcase
    end
  end

  always_comb begin
    ctl            = '0;
    ctl.phase      = phase;
    ctl.lanes      = lanesNow;
    ctl.stepIdx    = stepIdx;
    ctl.byteIdx    = byteIdx;
    ctl.sckHigh    = sckHigh;
    ctl.sampleEn   = (phase == PH_DATA) && !sckHigh && halfEnd;
    ctl.sampleLast = ctl.sampleEn && lastStep;
    ctl.capture    = (phase == PH_IDLE) && busReq && mapEnable;
  end

endmodule

// File: rtl/sfr_datapath.sv
module sfr_datapath
  import sfr_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_BYTES = 4,
  localparam int DATA_W    = 8 * DATA_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_ctl_t          ctl,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        cmdCode,
  input  logic [2:0]        addrBytes,
  input  logic [7:0]        padCode,
  input  logic [3:0]        flashDi,
  output logic              seqCsN,
  output logic              seqSck,
  output logic [3:0]        seqDo,
  output logic [3:0]        seqOe,
  output logic              busAck,
  output logic              busErr,
  output logic [DATA_W-1:0] busRdata
);

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] rdWord;
  logic [7:0]        rxByte, rxNext;
  logic [2:0]        addrLen, addrSel;
  logic [ADDR_W-1:0] addrShift;
  logic [7:0]        outByte, shifted;

  assign addrLen   = (addrBytes > 3'd4) ? 3'd4 : addrBytes;
  assign addrSel   = addrLen - 3'd1 - ctl.byteIdx;
  assign addrShift = addrReg >> {addrSel, 3'b000};

  always_comb begin
    unique case (ctl.phase)
      PH_CMD:  outByte = cmdCode;
      PH_ADDR: outByte = addrShift[7:0];
      PH_PAD:  outByte = padCode;
      default: outByte = 8'h00;
    endcase
  end

  always_comb begin
    unique case (ctl.lanes)
      2'd1:    shifted = outByte << {ctl.stepIdx[1:0], 1'b0};
      2'd2:    shifted = outByte << {ctl.stepIdx[0], 2'b00};
      default: shifted = outByte << ctl.stepIdx[2:0];
    endcase
  end

  always_comb begin
    seqDo = 4'h0;
    seqOe = 4'h0;
    if ((ctl.phase == PH_CMD) || (ctl.phase == PH_ADDR)) begin
      unique case (ctl.lanes)
        2'd1: begin seqDo = {2'b00, shifted[7:6]}; seqOe = 4'b0011; end
        2'd2: begin seqDo = shifted[7:4];          seqOe = 4'b1111; end
        default: begin seqDo = {3'b000, shifted[7]}; seqOe = 4'b0001; end
      endcase
    end else if ((ctl.phase == PH_PAD) && (ctl.stepIdx < 5'd8)) begin
      seqDo = {3'b000, shifted[7]};
      seqOe = 4'b0001;
    end
  end

  always_comb begin
    unique case (ctl.lanes)
      2'd1:    rxNext = {rxByte[5:0], flashDi[1:0]};
      2'd2:    rxNext = {rxByte[3:0], flashDi};
      default: rxNext = {rxByte[6:0], flashDi[1]};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrReg <= '0;
      rdWord  <= '0;
      rxByte  <= '0;
    end else begin
      if (ctl.capture) begin
        addrReg <= busAddr;
        rdWord  <= '0;
        rxByte  <= '0;
      end else if (ctl.sampleEn) begin
        rxByte <= rxNext;
        if (ctl.sampleLast) begin
          for (int b = 0; b < DATA_BYTES; b++) begin
            if (ctl.byteIdx == 3'(b)) rdWord[b*8 +: 8] <= rxNext;
          end
        end
      end
    end
  end

  assign seqCsN   = !isActive(ctl.phase);
  assign seqSck   = isActive(ctl.phase) && ctl.sckHigh;
  assign busAck   = (ctl.phase == PH_DONE) || (ctl.phase == PH_FAIL);
  assign busErr   = (ctl.phase == PH_FAIL);
  assign busRdata = (ctl.phase == PH_DONE) ? rdWord : '0;

endmodule

// File: rtl/sflash_map_reader.sv
module sflash_map_reader
  import sfr_pkg::*;
#(
  parameter int SCK_HALF   = 1,
  parameter int ADDR_W     = 32,
  parameter int DATA_BYTES = 4,
  localparam int DATA_W    = 8 * DATA_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mapEnable,
  input  logic              cmdEnable,
  input  logic [7:0]        cmdCode,
  input  logic [2:0]        addrBytes,
  input  logic [4:0]        padCycles,
  input  logic [7:0]        padCode,
  input  logic [1:0]        cmdLanes,
  input  logic [1:0]        addrLanes,
  input  logic [1:0]        dataLanes,
  input  logic              dirCsN,
  input  logic              dirSck,
  input  logic [3:0]        dirDo,
  input  logic [3:0]        dirOe,
  input  logic              busReq,
  input  logic [ADDR_W-1:0] busAddr,
  output logic              busAck,
  output logic              busErr,
  output logic [DATA_W-1:0] busRdata,
  output logic              flashCsN,
  output logic              flashSck,
  output logic [3:0]        flashDo,
  output logic [3:0]        flashOe,
  input  logic [3:0]        flashDi
);

  seq_ctl_t   ctl;
  logic       seqCsN, seqSck;
  logic [3:0] seqDo, seqOe;

  sfr_ctrl #(.SCK_HALF(SCK_HALF), .DATA_BYTES(DATA_BYTES)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .busReq(busReq), .mapEnable(mapEnable),
    .cmdEnable(cmdEnable), .addrBytes(addrBytes), .padCycles(padCycles),
    .cmdLanes(cmdLanes), .addrLanes(addrLanes), .dataLanes(dataLanes),
    .ctl(ctl)
  );

  sfr_datapath #(.ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES)) i_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .busAddr(busAddr),
    .cmdCode(cmdCode), .addrBytes(addrBytes), .padCode(padCode),
    .flashDi(flashDi), .seqCsN(seqCsN), .seqSck(seqSck), .seqDo(seqDo),
    .seqOe(seqOe), .busAck(busAck), .busErr(busErr), .busRdata(busRdata)
  );

  assign flashCsN = mapEnable ? seqCsN : dirCsN;
  assign flashSck = mapEnable ? seqSck : dirSck;
  assign flashDo  = mapEnable ? seqDo  : dirDo;
  assign flashOe  = mapEnable ? seqOe  : dirOe;

endmodule

// File: rtl/sfr_checker.sv
module sfr_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mapEnable,
  input logic              flashCsN,
  input logic              flashSck,
  input logic              busAck,
  input logic              busErr,
  input logic [DATA_W-1:0] busRdata
);

  a_r8_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mapEnable && flashCsN) |-> !flashSck);

  a_r8_rise_only_selected: assert property (@(posedge clk) disable iff (!rst_n)
    (mapEnable && $rose(flashSck)) |-> !flashCsN);

  a_r9_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    busAck |=> !busAck);

  a_r9_cs_released_at_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (mapEnable && busAck && !busErr) |-> flashCsN);

  a_r1_err_zero_word: assert property (@(posedge clk) disable iff (!rst_n)
    busErr |-> (busAck && (busRdata == '0)));

endmodule

bind sflash_map_reader sfr_checker #(.DATA_W(DATA_W)) i_sfr_checker (
  .clk(clk), .rst_n(rst_n), .mapEnable(mapEnable), .flashCsN(flashCsN),
  .flashSck(flashSck), .busAck(busAck), .busErr(busErr), .busRdata(busRdata)
);

// File: tb/test_sflash_map_reader.sv
`timescale 1ns/1ps
module test_sflash_map_reader;

  localparam int HALF = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mapEnable = 0, cmdEnable = 0;
  logic [7:0] cmdCode = 0, padCode = 0;
  logic [2:0] addrBytes = 0;
  logic [4:0] padCycles = 0;
  logic [1:0] cmdLanes = 0, addrLanes = 0, dataLanes = 0;
  logic dirCsN = 1, dirSck = 0;
  logic [3:0] dirDo = 0, dirOe = 0;
  logic busReq = 0;
  logic [31:0] busAddr = 0;
  logic busAck, busErr;
  logic [31:0] busRdata;
  logic flashCsN, flashSck;
  logic [3:0] flashDo, flashOe;
  logic [3:0] flashDi = 4'h0;

  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  sflash_map_reader #(.SCK_HALF(HALF)) i_sflash_map_reader (.*);

  // Flash model: records lanes at each SCK rise, drives read data after falls.
  logic [3:0] capDo [0:255];
  logic [3:0] capOe [0:255];
  int riseCnt = 0;
  int preSteps = 0;
  int modelLanes = 0;
  logic [7:0] modelBytes [0:3];
  logic prevCs = 1'b1, prevSck = 1'b0;

  function automatic int norm(input int c);
    return (c == 3) ? 2 : c;
  endfunction

  function automatic logic [3:0] chunkOf(input logic [7:0] b, input int ln, input int s);
    logic [7:0] sh;
    if (ln == 0) begin sh = b << s;     return {3'b0, sh[7]}; end
    if (ln == 1) begin sh = b << (2*s); return {2'b0, sh[7:6]}; end
    sh = b << (4*s);
    return sh[7:4];
  endfunction

  task automatic modelDrive(input int n);
    int spb, k, s;
    logic [3:0] c;
    spb = 8 >> modelLanes;
    if (n >= preSteps && n - preSteps < 4*spb) begin
      k = (n - preSteps) / spb;
      s = (n - preSteps) % spb;
      c = chunkOf(modelBytes[k], modelLanes, s);
      if (modelLanes == 0) flashDi = {2'b0, c[0], 1'b0};
      else flashDi = c;
    end else begin
      flashDi = 4'h0;
    end
  endtask

  always @(flashCsN or flashSck) begin
    if (prevCs && !flashCsN) begin
      riseCnt = 0;
      modelDrive(0);
    end else if (!flashCsN && !prevSck && flashSck) begin
      if (riseCnt < 256) begin
        capDo[riseCnt] = flashDo;
        capOe[riseCnt] = flashOe;
      end
      riseCnt++;
    end else if (!flashCsN && prevSck && !flashSck) begin
      modelDrive(riseCnt);
    end
    prevCs  = flashCsN;
    prevSck = flashSck;
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Expected lane sequence
  logic [3:0] expDo [0:255];
  logic [3:0] expOe [0:255];
  int expN = 0;

  task automatic pushByte(input logic [7:0] b, input int ln);
    for (int s = 0; s < (8 >> ln); s++) begin
      expDo[expN] = chunkOf(b, ln, s);
      expOe[expN] = (ln == 0) ? 4'b0001 : (ln == 1) ? 4'b0011 : 4'b1111;
      expN++;
    end
  endtask

  task automatic waitAck(output int cyc);
    cyc = 0;
    do begin
      @(posedge clk); cyc++;
      @(negedge clk);
    end while (!busAck && cyc < 2000);
    if (!busAck) chk("R9", "watchdog ack", 0, 1);
  endtask

  task automatic mappedRead(input string tag, input logic ce, input logic [7:0] cc,
                            input int ab, input int pc, input logic [7:0] pcode,
                            input int cl, input int al, input int dl,
                            input logic [31:0] addr, input logic [31:0] word);
    int nA, cyc, bad, dataBad, steps;
    @(negedge clk);
    mapEnable = 1; cmdEnable = ce; cmdCode = cc; addrBytes = 3'(ab);
    padCycles = 5'(pc); padCode = pcode;
    cmdLanes = 2'(cl); addrLanes = 2'(al); dataLanes = 2'(dl);
    nA = (ab > 4) ? 4 : ab;
    expN = 0;
    if (ce) pushByte(cc, norm(cl));
    for (int i = nA - 1; i >= 0; i--) pushByte(addr[8*i +: 8], norm(al));
    for (int p = 0; p < pc; p++) begin
      expDo[expN] = (p < 8) ? {3'b0, pcode[7-p]} : 4'h0;
      expOe[expN] = (p < 8) ? 4'b0001 : 4'b0000;
      expN++;
    end
    preSteps = expN;
    modelLanes = norm(dl);
    for (int k = 0; k < 4; k++) modelBytes[k] = word[8*k +: 8];
    steps = preSteps + 4 * (8 >> modelLanes);
    busAddr = addr; busReq = 1;
    waitAck(cyc);
    chk("R7", {tag, " read word"}, busRdata, word);
    chk("R9", {tag, " no error"}, busErr, 0);
    chk("R9", {tag, " cs high at ack"}, flashCsN, 1);
    chk("R8", {tag, " cycles to ack"}, cyc, 1 + 2*HALF*steps);
    chk("R2", {tag, " sck rises"}, riseCnt, steps);
    bad = 0;
    for (int i = 0; i < preSteps; i++)
      if (capDo[i] !== expDo[i] || capOe[i] !== expOe[i]) bad++;
    chk(tag, " command/address/pad lanes mismatches", bad, 0);
    dataBad = 0;
    for (int i = preSteps; i < steps && i < 256; i++)
      if (capOe[i] !== 4'h0) dataBad++;
    chk("R7", {tag, " data part drives no lane"}, dataBad, 0);
    busReq = 0;
    @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk);
    mapEnable = 1;
    #1;
    chk("R8", "reset cs", flashCsN, 1);
    chk("R8", "reset sck", flashSck, 0);
    chk("R6", "reset oe", flashOe, 0);
    chk("R9", "reset ack", busAck, 0);
  endtask

  task automatic testDirect();
    int cyc;
    @(negedge clk);
    mapEnable = 0;
    for (int p = 0; p < 3; p++) begin
      dirCsN = p[0]; dirSck = !p[0]; dirDo = 4'(5 + 3*p); dirOe = 4'(9 - 2*p);
      #1;
      chk("R1", "direct cs", flashCsN, dirCsN);
      chk("R1", "direct sck", flashSck, dirSck);
      chk("R1", "direct do/oe", {flashDo, flashOe}, {dirDo, dirOe});
      @(negedge clk);
    end
    dirCsN = 1; dirSck = 0; dirDo = 4'hA; dirOe = 4'h3;
    busAddr = 32'h1234; busReq = 1;
    waitAck(cyc);
    chk("R1", "refused read ack", {busAck, busErr}, 2'b11);
    chk("R1", "refused read word", busRdata, 0);
    chk("R1", "refused read latency", cyc, 1);
    chk("R1", "pins stay direct", {flashCsN, flashSck, flashDo, flashOe}, {1'b1, 1'b0, 4'hA, 4'h3});
    busReq = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R9", "ack gone after pulse", busAck, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1;
    testReset();
    testDirect();
    mappedRead("R2", 1, 8'h03, 3, 0, 8'h00, 0, 0, 0, 32'h00A1B2C3, 32'hDEADBEEF);
    mappedRead("R5", 0, 8'h00, 4, 10, 8'hB4, 0, 1, 1, 32'h12345678, 32'h0F1E2D3C);
    mappedRead("R6", 1, 8'hEB, 0, 0, 8'h00, 2, 2, 2, 32'h00000040, 32'hA55A3CC3);
    mappedRead("R5", 1, 8'h3B, 1, 3, 8'h5A, 1, 0, 2, 32'h000000E7, 32'h80402010);
    mappedRead("R4", 1, 8'h0B, 7, 0, 8'h00, 3, 0, 0, 32'h89ABCDEF, 32'h01234567);
    mappedRead("R3", 0, 8'h00, 0, 0, 8'h00, 0, 0, 0, 32'h00000000, 32'hC001D00D);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule